// File: doc/BRIEF.md
# Phase-Aligned Double-Rate Sample Strobe

This block carries a stream of 16-bit samples from a slow clock into a fast clock that runs at exactly twice the slow frequency. Both clocks come from one frequency synthesizer, so every slow rising edge lands on a fast rising edge. The block marks each new sample with a one-cycle valid pulse in the fast domain, so that a downstream filter can run at the fast rate and share its multipliers between two time slots. The effective sample rate stays at the slow rate.

The clocks are phase-locked, so no dual-clock queue is needed. On every slow edge the slow side registers the sample and inverts a one-bit marker. The fast side passes the marker through two registers and compares their outputs. A difference starts a strobe cycle and loads the held sample into the output register.

The capture state machine has three states. CAP_IDLE: no sample seen since reset. CAP_STROBE: valid is high. CAP_GAP: waiting between samples. A marker change moves any state to CAP_STROBE. With no change, CAP_STROBE moves to CAP_GAP, and CAP_IDLE and CAP_GAP stay where they are. A second state machine watches the strobes. LM_DISARMED moves to LM_TRACK on the first strobe after reset. LM_TRACK moves to LM_FAULT on two strobes in a row, or on three strobe-free fast cycles in a row. LM_FAULT holds until reset.

Top module: `strobe_2x_xfer`

## Requirements
- R1: Each slow rising edge taken while neither reset is active captures `smp_in`, and exactly one strobe follows it. Strobes present the captured samples in capture order on `smp_out`.
- R2: While the clocks stay locked at the 2:1 ratio, `smp_vld` is high in exactly one of every two fast cycles and is never high in two consecutive fast cycles.
- R3: Take a sample captured at a slow rising edge that coincides with fast rising edge F0. `smp_vld` rises at fast edge F0+2 with that sample on `smp_out`. It is low after edges F0 and F0+1.
- R4: `smp_out` changes only in a cycle where `smp_vld` is high. It holds its value between strobes, including when the slow clock stops.
- R5: While `rst_fast` or `rst_slow` is high, `smp_vld` and `lock_err` are low. A fast edge taken with either reset high clears `smp_out` to zero.
- R6: The first strobe after both resets are released carries the first sample captured after release. No stale value is presented.
- R7: Two consecutive fast cycles with `smp_vld` high set `lock_err`.
- R8: Once a strobe has been seen since reset, three consecutive fast cycles with `smp_vld` low set `lock_err`. Before that first strobe, no count is kept, and `lock_err` stays low during normal 2:1 operation.
- R9: `lock_err` stays high once set, until a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Slow sample clock, half the fast rate, edges aligned with clk_fast |
| rst_slow | input | 1 | Synchronous active-high reset, slow domain |
| smp_in | input | 16 | Incoming sample, one per slow cycle |
| clk_fast | input | 1 | Fast processing clock |
| rst_fast | input | 1 | Synchronous active-high reset, fast domain |
| smp_out | output | 16 | Sample presented to the fast domain |
| smp_vld | output | 1 | One-cycle strobe marking a new sample on smp_out |
| lock_err | output | 1 | Sticky flag for a broken 2:1 strobe pattern |

## Verification
The hardest conditions to reach from the ports are the lock faults, because a correctly locked clock pair can never produce them. The bench drives both clocks from one generator with a mode control. One mode freezes the slow clock, which yields the strobe-free run that sets the fault. Another mode toggles the slow clock on both fast edges, so the marker changes every fast cycle and strobes come back to back. The cycle-exact latency after reset release and the hold of `smp_out` while the slow side is frozen are also checked directly.

// File: rtl/strobe2x_pkg.sv
package strobe2x_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE   = 2'd0,
        CAP_STROBE = 2'd1,
        CAP_GAP    = 2'd2
    } cap_state_e;

    typedef enum logic [1:0] {
        LM_DISARMED = 2'd0,
        LM_TRACK    = 2'd1,
        LM_FAULT    = 2'd2
    } lock_state_e;

endpackage

// File: rtl/slow_launch.sv
module slow_launch #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] smp_in,
    output logic [DATA_W-1:0] held_q,
    output logic              flip_q
);

    // Sample register and marker bit, both updated on every slow edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            flip_q <= 1'b0;
        end else begin
            held_q <= smp_in;
            flip_q <= ~flip_q;
        end
    end

    // R1
    toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (flip_q != $past(flip_q)));

endmodule

// File: rtl/fast_capture.sv
module fast_capture
    import strobe2x_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flip_in,
    input  logic [DATA_W-1:0] held_in,
    output logic              vld,
    output logic [DATA_W-1:0] dout
);

    logic              flip_q1;
    logic              flip_q2;
    logic              change;
    cap_state_e        state_q;
    cap_state_e        state_d;
    logic [DATA_W-1:0] dout_q;

    // Two-stage marker pipeline in the fast domain.
    always_ff @(posedge clk) begin
        if (rst) begin
            flip_q1 <= 1'b0;
            flip_q2 <= 1'b0;
        end else begin
            flip_q1 <= flip_in;
            flip_q2 <= flip_q1;
        end
    end

    assign change = flip_q1 ^ flip_q2;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE:   state_d = change ? CAP_STROBE : CAP_IDLE;
            CAP_STROBE: state_d = change ? CAP_STROBE : CAP_GAP;
            CAP_GAP:    state_d = change ? CAP_STROBE : CAP_GAP;
            default:    state_d = CAP_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= CAP_IDLE;
        else     state_q <= state_d;
    end

    // Output register: loads only when a strobe cycle begins.
    always_ff @(posedge clk) begin
        if (rst)                         dout_q <= '0;
        else if (state_d == CAP_STROBE)  dout_q <= held_in;
    end

    assign vld  = (state_q == CAP_STROBE);
    assign dout = dout_q;

    // R4
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        (dout != $past(dout)) |-> vld);

    // R5
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!vld && dout == '0));

endmodule

// File: rtl/lock_watch.sv
module lock_watch
    import strobe2x_pkg::*;
#(
    parameter int IDLE_LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic vld,
    output logic err
);

    localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST_IDLE = CNT_W'(IDLE_LIMIT - 1);

    lock_state_e      state_q;
    lock_state_e      state_d;
    logic             vld_prev;
    logic [CNT_W-1:0] idle_cnt;
    logic             back_to_back;
    logic             starved;

    assign back_to_back = vld && vld_prev;
    assign starved      = !vld && (idle_cnt == LAST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LM_DISARMED: begin
                if (back_to_back) state_d = LM_FAULT;
                else if (vld)     state_d = LM_TRACK;
            end
            LM_TRACK: begin
                if (back_to_back || starved) state_d = LM_FAULT;
            end
            LM_FAULT: state_d = LM_FAULT;
            default:  state_d = LM_DISARMED;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= LM_DISARMED;
        else     state_q <= state_d;
    end

    // History and gap counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_prev <= 1'b0;
            idle_cnt <= '0;
        end else begin
            vld_prev <= vld;
            if (vld)
                idle_cnt <= '0;
            else if (state_q == LM_TRACK && idle_cnt != LAST_IDLE)
                idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign err = (state_q == LM_FAULT);

    // R7
    double_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && $past(vld)) |=> err);

    // R9
    sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R5
    reset_err_chk: assert property (@(posedge clk)
        rst |=> !err);

endmodule

// File: rtl/strobe_2x_xfer.sv
module strobe_2x_xfer #(
    parameter int DATA_W     = 16,
    parameter int IDLE_LIMIT = 3
) (
    input  logic              clk_slow,
    input  logic              rst_slow,
    input  logic [DATA_W-1:0] smp_in,
    input  logic              clk_fast,
    input  logic              rst_fast,
    output logic [DATA_W-1:0] smp_out,
    output logic              smp_vld,
    output logic              lock_err
);

    logic [DATA_W-1:0] held;
    logic              flip;
    logic              rst_any;

    // rst_slow changes only on slow edges, which are also fast edges.
    assign rst_any = rst_fast | rst_slow;

    slow_launch #(.DATA_W(DATA_W)) u_launch (
        .clk    (clk_slow),
        .rst    (rst_slow),
        .smp_in (smp_in),
        .held_q (held),
        .flip_q (flip)
    );

    fast_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk_fast),
        .rst     (rst_any),
        .flip_in (flip),
        .held_in (held),
        .vld     (smp_vld),
        .dout    (smp_out)
    );

    lock_watch #(.IDLE_LIMIT(IDLE_LIMIT)) u_watch (
        .clk (clk_fast),
        .rst (rst_any),
        .vld (smp_vld),
        .err (lock_err)
    );

endmodule

// File: tb/strobe_2x_xfer_tb.sv
module strobe_2x_xfer_tb;

    logic        clk_fast = 1'b0;
    logic        clk_slow = 1'b0;
    logic        rst_fast = 1'b1;
    logic        rst_slow = 1'b1;
    logic [15:0] smp_in   = 16'h0;
    logic [15:0] smp_out;
    logic        smp_vld;
    logic        lock_err;

    int          n_chk     = 0;
    int          n_fail    = 0;
    int          slow_mode = 0;   // 0 locked, 1 frozen, 2 double rate
    bit          sb_en     = 1'b0;
    bit          done      = 1'b0;
    logic [15:0] exp_q[$];
    logic [15:0] prev_out  = 16'h0;

    strobe_2x_xfer u_dut (
        .clk_slow (clk_slow),
        .rst_slow (rst_slow),
        .smp_in   (smp_in),
        .clk_fast (clk_fast),
        .rst_fast (rst_fast),
        .smp_out  (smp_out),
        .smp_vld  (smp_vld),
        .lock_err (lock_err)
    );

    // 250 MHz fast clock; slow clock derived in the same process.
    initial forever begin
        #2;
        clk_fast = 1'b1;
        if (slow_mode != 1) clk_slow = ~clk_slow;
        #2;
        clk_fast = 1'b0;
        if (slow_mode == 2) clk_slow = ~clk_slow;
    end

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver side: each slow edge out of reset queues the sample it captures.
    always @(posedge clk_slow) begin
        automatic logic [15:0] v    = smp_in;
        automatic bit          live = !rst_slow && !rst_fast && sb_en;
        #5;
        if (live && sb_en) exp_q.push_back(v);
    end

    // Monitor: compare strobed data and check the hold between strobes.
    always @(negedge clk_fast) begin
        if (sb_en && !rst_fast && !rst_slow) begin
            if (smp_vld) begin
                if (exp_q.size() == 0) begin
                    check("R1", 32'd1, 32'd0, "strobe with nothing pending");
                end else begin
                    automatic logic [15:0] e = exp_q.pop_front();
                    check("R1", {16'h0, smp_out}, {16'h0, e}, "strobed sample");
                end
            end else begin
                check("R4", {16'h0, smp_out}, {16'h0, prev_out}, "hold without strobe");
            end
        end
        prev_out = smp_out;
    end

    function automatic logic [15:0] pattern(input int kind, input int i);
        case (kind)
            0:       return 16'(i + 16'h0100);
            1:       return 16'h1 << (i % 16);
            2:       return (i % 2) ? 16'hFFFF : 16'h0000;
            default: return 16'(i * 16'h9E37) ^ 16'h5A5A;
        endcase
    endfunction

    task automatic stream(input int n, input int kind);
        for (int i = 0; i < n; i++) begin
            @(posedge clk_slow);
            #1;
            smp_in = pattern(kind, i);
        end
    endtask

    task automatic reset_all();
        @(posedge clk_slow);
        #1;
        sb_en    = 1'b0;
        rst_fast = 1'b1;
        rst_slow = 1'b1;
        repeat (4) @(negedge clk_fast);
        check("R5", {31'h0, smp_vld}, 32'd0, "valid in reset");
        check("R5", {16'h0, smp_out}, 32'd0, "output in reset");
        check("R5", {31'h0, lock_err}, 32'd0, "error in reset");
    endtask

    task automatic release_all(input logic [15:0] first);
        @(posedge clk_slow);
        #1;
        exp_q.delete();
        smp_in   = first;
        rst_fast = 1'b0;
        rst_slow = 1'b0;
        sb_en    = 1'b1;
    endtask

    initial begin
        // Reset state
        reset_all();

        // R3 / R6: exact latency and first sample after release
        release_all(16'hA5C3);
        @(posedge clk_slow);                 // capture edge F0
        @(negedge clk_fast);
        check("R3", {31'h0, smp_vld}, 32'd0, "valid after F0");
        @(negedge clk_fast);
        check("R3", {31'h0, smp_vld}, 32'd0, "valid after F0+1");
        @(negedge clk_fast);
        check("R3", {31'h0, smp_vld}, 32'd1, "valid after F0+2");
        check("R6", {16'h0, smp_out}, 32'h0000A5C3, "first sample after release");

        // R1 under several patterns
        stream(20, 0);
        stream(20, 1);
        stream(16, 2);
        stream(24, 3);

        // R2 duty and R8 no false error while locked
        begin
            automatic int   hi  = 0;
            automatic int   dbl = 0;
            automatic logic pv;
            @(negedge clk_fast);
            pv = smp_vld;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk_fast);
                if (smp_vld) hi++;
                if (smp_vld && pv) dbl++;
                pv = smp_vld;
            end
            check("R2", 32'(hi), 32'd10, "strobes in 20 fast cycles");
            check("R2", 32'(dbl), 32'd0, "back-to-back strobes");
            check("R8", {31'h0, lock_err}, 32'd0, "no error while locked");
        end

        // R5: slow-side reset alone keeps the strobe low and the watcher disarmed
        @(posedge clk_slow);
        #1;
        sb_en    = 1'b0;
        rst_slow = 1'b1;
        repeat (2) @(negedge clk_fast);
        begin
            automatic int hi = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk_fast);
                if (smp_vld) hi++;
            end
            check("R5", 32'(hi), 32'd0, "strobes during slow reset");
            check("R8", {31'h0, lock_err}, 32'd0, "no error before arming");
        end
        @(posedge clk_slow);
        #1;
        exp_q.delete();
        rst_slow = 1'b0;
        sb_en    = 1'b1;
        stream(12, 1);

        // R8 / R4: freeze the slow clock
        @(posedge clk_slow);
        #1;
        sb_en     = 1'b0;
        slow_mode = 1;
        begin
            automatic logic [15:0] hold;
            automatic int          hi = 0;
            repeat (3) @(negedge clk_fast);
            hold = smp_out;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk_fast);
                if (smp_vld) hi++;
            end
            check("R4", 32'(hi), 32'd0, "strobes while slow clock stopped");
            check("R4", {16'h0, smp_out}, {16'h0, hold}, "output held while stopped");
            check("R8", {31'h0, lock_err}, 32'd1, "error after strobe-free run");
        end

        // R9: error stays set after the clock resumes
        slow_mode = 0;
        repeat (12) @(negedge clk_fast);
        check("R9", {31'h0, lock_err}, 32'd1, "error sticky after resume");

        // R5: reset clears the error
        reset_all();
        release_all(16'h3C3C);
        stream(10, 3);
        check("R7", {31'h0, lock_err}, 32'd0, "no error before double rate");

        // R7: double-rate slow clock gives back-to-back strobes
        @(posedge clk_slow);
        #1;
        sb_en     = 1'b0;
        slow_mode = 2;
        repeat (10) @(negedge clk_fast);
        check("R7", {31'h0, lock_err}, 32'd1, "error after back-to-back strobes");
        slow_mode = 0;
        repeat (4) @(negedge clk_fast);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule